// File: doc/BRIEF.md
# Single-Cycle 36-bit Skip-Conditional Controller Core

A small control processor that executes one 36-bit instruction per clock. Each instruction reads two operands from a 512-word register file, combines them in an eight-function add/sub/logic unit, rotates the result right, and writes it back. The core has no branch instructions and no flag register. Conditional flow comes only from an optional skip over the next instruction. Every jump takes its target from the ALU result and saves a return address.

The ALU result of the previous instruction can replace the A read address or the write address. This is the only way to reach the upper half of the register file, which powers up holding constants. Two register addresses also have effects at the ports. Writing register 255 updates an output latch. Writing register 253 sends a one-cycle command strobe with data to a downstream engine.

Instruction memory is outside the core. The core presents the PC on `imem_addr_o` and takes the addressed word on `imem_data_i` in the same cycle.

Top module: `tc_core`

## Requirements
- R1: Asynchronous reset (`rst_ni` low) sets the PC to 1, the saved previous ALU result to 0, `out_o` to 0, `cmd_valid_o` to 0, and registers 0..255 to 0. Each register k in 256..511 is set to the value k-256.
- R2: The instruction word is laid out as: Rw in bits 35:28, Ra in bits 27:19, Rb in bits 18:10, function in bits 9:7, shift in bits 6:5, skip in bits 4:2, op in bits 1:0. The function codes are:
  - 0: A+B
  - 1: A-B
  - 2: A&B
  - 3: A&`in_data_i` (the bus replaces B)
  - 4: A|B
  - 5: A|~B
  - 6: A^B
  - 7: A&~B
- R3: Shift code 0 passes the function result unchanged. Codes 1, 2 and 3 rotate it right by 1, 9 and 18 bits.
- R4: The skip condition is evaluated on the rotated result. Skip codes are:
  - 0: never
  - 1: bit 35 set
  - 2: zero
  - 3: `in_ready_i` high
  - 4: always
  - 5: bit 35 clear
  - 6: nonzero
  - 7: `in_ready_i` low

  A taken skip advances the PC by 2; otherwise the PC advances by 1.
- R5: Op 0 writes the result to register {0,Rw}. Registers 256..511 can never be written through Rw.
- R6: Op 1 reads operand A from the register addressed by the low 9 bits of the previous non-jump ALU result, instead of Ra.
- R7: Op 2 writes the result to the register addressed by the low 9 bits of the previous non-jump ALU result, which may lie in 256..511.
- R8: Op 3 writes PC+1 (zero-extended) into {0,Rw} and loads the PC from result bits 9:0. It ignores the skip field and leaves the saved previous ALU result unchanged. Every other op updates the saved result.
- R9: Any write to register 255, by any op, also loads `out_o` with the written value on the same edge. `out_o` holds otherwise.
- R10: Any write to register 253 raises `cmd_valid_o` for exactly the following cycle, with `cmd_data_o` equal to the written value.
- R11: The 10-bit PC wraps from 1023 to 0 (and from 1022 to 0 on a skip).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_addr_o | output | 10 | Current PC, fetch address |
| imem_data_i | input | 36 | Instruction word at `imem_addr_o` |
| in_data_i | input | 36 | External data bus, used by function 3 |
| in_ready_i | input | 1 | External data ready flag, used by skip codes 3 and 7 |
| out_o | output | 36 | Output latch loaded by writes to register 255 |
| cmd_valid_o | output | 1 | One-cycle strobe after a write to register 253 |
| cmd_data_o | output | 36 | Value written to register 253 |

## Verification
A wrong PC update shows up on `imem_addr_o` at the very next edge, because the fetch address is the PC register itself. A corrupted register, constant or saved ALU result stays hidden until some later instruction reads it and stores into register 255 or 253. That can take an arbitrary number of cycles. The stimulus therefore sends a large share of random writes to those two addresses and compares the port values on every cycle against a bench instruction model.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_AND = 3'd2, FN_AND_IN = 3'd3,
    FN_OR  = 3'd4, FN_ORN = 3'd5, FN_XOR = 3'd6, FN_ANDN = 3'd7
  } fn_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0, SH_ROT_A = 2'd1, SH_ROT_B = 2'd2, SH_ROT_C = 2'd3
  } sh_e;

  typedef enum logic [2:0] {
    SK_NEVER = 3'd0, SK_NEG = 3'd1, SK_ZERO = 3'd2, SK_RDY  = 3'd3,
    SK_ALWAYS = 3'd4, SK_NNEG = 3'd5, SK_NZERO = 3'd6, SK_NRDY = 3'd7
  } sk_e;

  typedef enum logic [1:0] {
    OP_ALU = 2'd0, OP_IDX_RD = 2'd1, OP_IDX_WR = 2'd2, OP_JUMP = 2'd3
  } op_e;
endpackage

// File: rtl/tc_alu.sv
module tc_alu
  import tc_pkg::*;
#(
  parameter int unsigned DW   = 36,
  parameter int unsigned ROT1 = 1,
  parameter int unsigned ROT2 = 9,
  parameter int unsigned ROT3 = 18
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] in_data_i,
  input  fn_e           fn_i,
  input  sh_e           sh_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0]   f;
  logic [2*DW-1:0] dbl;
  logic [2*DW-1:0] rot;

  always_comb begin
    unique case (fn_i)
      FN_ADD:    f = a_i + b_i;
      FN_SUB:    f = a_i - b_i;
      FN_AND:    f = a_i & b_i;
      FN_AND_IN: f = a_i & in_data_i;
      FN_OR:     f = a_i | b_i;
      FN_ORN:    f = a_i | ~b_i;
      FN_XOR:    f = a_i ^ b_i;
      default:   f = a_i & ~b_i;
    endcase
  end

  // rotate right = low half of doubled word shifted right
  assign dbl = {f, f};
  always_comb begin
    unique case (sh_i)
      SH_NONE:  rot = dbl;
      SH_ROT_A: rot = dbl >> ROT1;
      SH_ROT_B: rot = dbl >> ROT2;
      default:  rot = dbl >> ROT3;
    endcase
  end
  assign res_o = rot[DW-1:0];
endmodule

// File: rtl/tc_skip.sv
module tc_skip
  import tc_pkg::*;
#(
  parameter int unsigned DW = 36
) (
  input  sk_e           sel_i,
  input  logic [DW-1:0] res_i,
  input  logic          in_ready_i,
  output logic          skip_o
);
  logic neg, zero;
  assign neg  = res_i[DW-1];
  assign zero = (res_i == '0);

  always_comb begin
    unique case (sel_i)
      SK_NEVER:  skip_o = 1'b0;
      SK_NEG:    skip_o = neg;
      SK_ZERO:   skip_o = zero;
      SK_RDY:    skip_o = in_ready_i;
      SK_ALWAYS: skip_o = 1'b1;
      SK_NNEG:   skip_o = ~neg;
      SK_NZERO:  skip_o = ~zero;
      default:   skip_o = ~in_ready_i;
    endcase
  end
endmodule

// File: rtl/tc_regfile.sv
module tc_regfile #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned HALF = NREG / 2;

  logic [DW-1:0] mem [NREG];

  // upper half comes out of reset holding its own offset as a constant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++)
        mem[i] <= (i < HALF) ? '0 : DW'(i - HALF);
    end else if (we_i) begin
      mem[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = mem[ra_i];
  assign rd_b_o = mem[rb_i];
endmodule

// File: rtl/tc_core.sv
module tc_core
  import tc_pkg::*;
#(
  parameter int unsigned DW         = 36,
  parameter int unsigned IM_AW      = 10,
  parameter int unsigned RF_AW      = 9,
  parameter int unsigned RW_W       = 8,
  parameter int unsigned OUT_REG    = 255,
  parameter int unsigned CMD_REG    = 253,
  parameter int unsigned START_ADDR = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IM_AW-1:0] imem_addr_o,
  input  logic [DW-1:0]    imem_data_i,
  input  logic [DW-1:0]    in_data_i,
  input  logic             in_ready_i,
  output logic [DW-1:0]    out_o,
  output logic             cmd_valid_o,
  output logic [DW-1:0]    cmd_data_o
);
  localparam int unsigned OP_LSB = 0;
  localparam int unsigned SK_LSB = OP_LSB + 2;
  localparam int unsigned SH_LSB = SK_LSB + 3;
  localparam int unsigned FN_LSB = SH_LSB + 2;
  localparam int unsigned RB_LSB = FN_LSB + 3;
  localparam int unsigned RA_LSB = RB_LSB + RF_AW;
  localparam int unsigned RW_LSB = RA_LSB + RF_AW;
  localparam logic [RF_AW-1:0] OUT_A = RF_AW'(OUT_REG);
  localparam logic [RF_AW-1:0] CMD_A = RF_AW'(CMD_REG);

  logic [IM_AW-1:0] pc_q, pc_inc1, pc_inc2, pc_d;
  logic [DW-1:0]    last_q, out_q, cmd_q;
  logic             cmd_v_q;

  op_e              op;
  fn_e              fn;
  sh_e              sh;
  sk_e              sk;
  logic [RW_W-1:0]  rw;
  logic [RF_AW-1:0] ra, rb, a_addr, wa;
  logic [DW-1:0]    a_val, b_val, alu_res, wd, link;
  logic             is_jump, skip_raw, skip_take;

  assign op = op_e'(imem_data_i[OP_LSB +: 2]);
  assign sk = sk_e'(imem_data_i[SK_LSB +: 3]);
  assign sh = sh_e'(imem_data_i[SH_LSB +: 2]);
  assign fn = fn_e'(imem_data_i[FN_LSB +: 3]);
  assign rb = imem_data_i[RB_LSB +: RF_AW];
  assign ra = imem_data_i[RA_LSB +: RF_AW];
  assign rw = imem_data_i[RW_LSB +: RW_W];

  assign is_jump = (op == OP_JUMP);
  assign a_addr  = (op == OP_IDX_RD) ? last_q[RF_AW-1:0] : ra;
  assign wa      = (op == OP_IDX_WR) ? last_q[RF_AW-1:0]
                                     : {{(RF_AW-RW_W){1'b0}}, rw};

  tc_regfile #(.DW(DW), .AW(RF_AW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (a_addr),
    .rb_i   (rb),
    .rd_a_o (a_val),
    .rd_b_o (b_val),
    .we_i   (1'b1),
    .wa_i   (wa),
    .wd_i   (wd)
  );

  tc_alu #(.DW(DW)) u_alu (
    .a_i       (a_val),
    .b_i       (b_val),
    .in_data_i (in_data_i),
    .fn_i      (fn),
    .sh_i      (sh),
    .res_o     (alu_res)
  );

  tc_skip #(.DW(DW)) u_skip (
    .sel_i      (sk),
    .res_i      (alu_res),
    .in_ready_i (in_ready_i),
    .skip_o     (skip_raw)
  );

  assign pc_inc1   = pc_q + IM_AW'(1);
  assign pc_inc2   = pc_q + IM_AW'(2);
  assign link      = {{(DW-IM_AW){1'b0}}, pc_inc1};
  assign wd        = is_jump ? link : alu_res;
  assign skip_take = skip_raw & ~is_jump;
  assign pc_d      = is_jump ? alu_res[IM_AW-1:0] : (skip_take ? pc_inc2 : pc_inc1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= IM_AW'(START_ADDR);
      last_q  <= '0;
      out_q   <= '0;
      cmd_v_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      pc_q    <= pc_d;
      if (!is_jump) last_q <= alu_res;
      if (wa == OUT_A) out_q <= wd;
      cmd_v_q <= (wa == CMD_A);
      if (wa == CMD_A) cmd_q <= wd;
    end
  end

  assign imem_addr_o = pc_q;
  assign out_o       = out_q;
  assign cmd_valid_o = cmd_v_q;
  assign cmd_data_o  = cmd_q;

  a_r4_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_jump |=> (pc_q == $past(pc_q) + IM_AW'(1)) || (pc_q == $past(pc_q) + IM_AW'(2)));

  a_r4_never_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_jump && sk == SK_NEVER) |=> pc_q == $past(pc_q) + IM_AW'(1));

  a_r8_last_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_jump |=> $stable(last_q));

  a_r8_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_jump |=> pc_q == $past(alu_res[IM_AW-1:0]));

  a_r9_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa != OUT_A) |=> $stable(out_o));

  a_r10_cmd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa == CMD_A) |=> cmd_valid_o && cmd_data_o == $past(wd));

  a_r10_cmd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa != CMD_A) |=> !cmd_valid_o);
endmodule

// File: tb/tc_core_tb.sv
`timescale 1ns/1ps
module tc_core_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  imem_addr;
  logic [35:0] imem_data, in_data, out, cmd_data;
  logic        in_ready, cmd_valid;

  logic [35:0] rom [1024];
  assign imem_data = rom[imem_addr];

  always #2 clk = ~clk;

  tc_core u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .imem_addr_o (imem_addr),
    .imem_data_i (imem_data),
    .in_data_i   (in_data),
    .in_ready_i  (in_ready),
    .out_o       (out),
    .cmd_valid_o (cmd_valid),
    .cmd_data_o  (cmd_data)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // bench model state
  logic [35:0] mrf [512];
  logic [9:0]  mpc;
  logic [35:0] mlast, mout, mcmd;
  logic        mcmdv;
  string       pc_tag;

  function automatic logic [35:0] ins(input int rw, input int ra, input int rb,
                                      input int fn, input int sh, input int sk, input int op);
    return {rw[7:0], ra[8:0], rb[8:0], fn[2:0], sh[1:0], sk[2:0], op[1:0]};
  endfunction

  function automatic int c(input int k);
    return 256 + k;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 512; i++) mrf[i] = (i < 256) ? 36'd0 : 36'(i - 256);
    mpc = 10'd1; mlast = '0; mout = '0; mcmd = '0; mcmdv = 1'b0;
  endtask

  task automatic model_step(input logic [35:0] ind, input logic rdy);
    logic [35:0] w, a, b, f, r, wd;
    logic [8:0]  ai, wa;
    logic [1:0]  op, sh;
    logic [2:0]  fn, sk;
    logic        tk;
    w  = rom[mpc];
    op = w[1:0]; sk = w[4:2]; sh = w[6:5]; fn = w[9:7];
    ai = (op == 2'd1) ? mlast[8:0] : w[27:19];
    a  = mrf[ai];
    b  = (fn == 3'd3) ? ind : mrf[w[18:10]];
    case (fn)
      3'd0: f = a + b;
      3'd1: f = a - b;
      3'd2, 3'd3: f = a & b;
      3'd4: f = a | b;
      3'd5: f = a | ~b;
      3'd6: f = a ^ b;
      default: f = a & ~b;
    endcase
    case (sh)
      2'd0: r = f;
      2'd1: r = {f[0], f[35:1]};
      2'd2: r = {f[8:0], f[35:9]};
      default: r = {f[17:0], f[35:18]};
    endcase
    case (sk)
      3'd0: tk = 1'b0;
      3'd1: tk = r[35];
      3'd2: tk = (r == 36'd0);
      3'd3: tk = rdy;
      3'd4: tk = 1'b1;
      3'd5: tk = ~r[35];
      3'd6: tk = (r != 36'd0);
      default: tk = ~rdy;
    endcase
    wa = (op == 2'd2) ? mlast[8:0] : {1'b0, w[35:28]};
    wd = (op == 2'd3) ? {26'd0, mpc + 10'd1} : r;
    pc_tag = (op == 2'd3) ? "R8" : ((mpc >= 10'd1022) ? "R11" : "R4");
    mcmdv = (wa == 9'd253);
    if (mcmdv) mcmd = wd;
    if (wa == 9'd255) mout = wd;
    mrf[wa] = wd;
    if (op != 2'd3) mlast = r;
    mpc = (op == 2'd3) ? r[9:0] : (mpc + (tk ? 10'd2 : 10'd1));
  endtask

  function automatic logic [35:0] rand_ins();
    int p, rw;
    logic [1:0] op;
    p  = int'($urandom % 100);
    op = (p < 8) ? 2'd3 : (p < 22) ? 2'd1 : (p < 36) ? 2'd2 : 2'd0;
    p  = int'($urandom % 100);
    rw = (p < 30) ? 255 : (p < 40) ? 253 : int'($urandom % 256);
    return ins(rw, int'($urandom % 512), int'($urandom % 512), int'($urandom % 8),
               int'($urandom % 4), int'($urandom % 8), int'(op));
  endfunction

  // directed checks at known cycle numbers
  task automatic directed(input int cyc);
    case (cyc)
      2:  chk("R2 sub", out, 36'd5);
      3:  chk("R3 rot1", out, 36'h8_0000_0003);
      4:  begin chk("R10 strobe", cmd_valid, 36'd1); chk("R10 data", cmd_data, 36'd10); end
      5:  begin chk("R10 single", cmd_valid, 36'd0); chk("R4 skip zero", imem_addr, 36'd7); end
      6:  chk("R8 jump", imem_addr, 36'd20);
      8:  chk("R6 idx read of link", out, 36'd8);
      11: chk("R7 idx write upper", out, 36'd7);
      12: chk("R5 rw 255", out, 36'd9);
      13: begin chk("R5 upper intact", out, 36'd255); chk("R1 const", out, 36'd255); end
      14: chk("R8 jump far", imem_addr, 36'd1023);
      15: begin chk("R11 wrap", imem_addr, 36'd0); chk("R9 out", out, 36'd1); end
      16: chk("R8 jump to rand", imem_addr, 36'd40);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) rom[i] = rand_ins();
    rom[1]  = ins(1,   c(5), c(3), 0, 0, 0, 0);
    rom[2]  = ins(255, 1,    c(3), 1, 0, 0, 0);
    rom[3]  = ins(255, c(5), c(3), 4, 1, 0, 0);
    rom[4]  = ins(253, c(9), c(3), 6, 0, 0, 0);
    rom[5]  = ins(2,   c(0), c(0), 0, 0, 2, 0);
    rom[6]  = ins(255, c(1), c(0), 0, 0, 0, 0);
    rom[7]  = ins(3,   c(20), c(0), 0, 0, 4, 3);
    rom[20] = ins(5,   c(3), c(0), 0, 0, 0, 0);
    rom[21] = ins(255, 0,    c(0), 0, 0, 0, 1);
    rom[22] = ins(6,   511,  511,  0, 0, 0, 0);
    rom[23] = ins(0,   c(7), c(0), 0, 0, 0, 2);
    rom[24] = ins(255, 510,  c(0), 0, 0, 0, 0);
    rom[25] = ins(255, c(9), c(0), 0, 0, 0, 0);
    rom[26] = ins(255, 511,  c(0), 0, 0, 0, 0);
    rom[27] = ins(8,   c(0), c(0), 5, 0, 0, 3);
    rom[1023] = ins(255, c(1), c(0), 0, 0, 0, 0);
    rom[0]  = ins(0,   c(40), c(0), 0, 0, 0, 3);

    rst_n = 1'b0; in_data = '0; in_ready = 1'b1;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1 pc", imem_addr, 36'd1);
    chk("R1 out", out, 36'd0);
    chk("R1 cmd", cmd_valid, 36'd0);
    rst_n = 1'b1;
    model_step(in_data, in_ready);

    for (int cyc = 1; cyc <= 3000; cyc++) begin
      @(negedge clk);
      chk(pc_tag, imem_addr, mpc);
      chk("R9", out, mout);
      chk("R10", cmd_valid, mcmdv);
      if (mcmdv) chk("R10", cmd_data, mcmd);
      directed(cyc);
      if (cyc >= 16) begin
        in_data  = 36'({$urandom(), $urandom()});
        in_ready = $urandom % 2 == 0;
      end
      model_step(in_data, in_ready);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule